// File: doc/BRIEF.md
# Flash Program and Chip-Erase Command Interface

This block sits between a host write port and a small NOR-style cell array. It turns host writes into two-cycle command sequences. A single-word program starts with one of two setup opcodes and ends with an address-and-data write. A full-chip erase starts with a setup opcode and ends with a confirm opcode. Each accepted sequence starts a stub write engine. The engine stays busy for a fixed number of cycles and then commits the result to the array.

The block keeps an 8-bit status register. This register holds a ready flag and sticky error flags. Checks on the programming-voltage input, the per-block lock inputs and the write-protect input decide whether an operation runs. If it does not run, these checks set specific error flags. After any program or erase command, the read port returns status instead of array data, and it keeps doing so until the read-array opcode is written. The array is a register file that resets to all ones. A fault-mask input marks cells that will not program, so that the verify step can be exercised.

The controller has five states:
- `ST_IDLE` waits for a command.
- `ST_PGM_SETUP` waits for the program data.
- `ST_ERS_SETUP` waits for the erase confirm.
- `ST_PGM_BUSY` and `ST_ERS_BUSY` count down the engine time.

The transitions are:
- program-setup: idle to program setup on opcode 40h or 10h.
- erase-setup: idle to erase setup on opcode 30h.
- program-launch: program setup to program busy.
- program-reject: program setup to idle.
- erase-launch: erase setup to erase busy.
- erase-reject: erase setup to idle.
- commit: busy to idle when the count expires.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the status register reads 80h, meaning ready with every error flag clear. Reads return array data, and every word reads all ones.
- R2: Writing 40h, or the alternate 10h, and then a write carrying address and data programs that word to old AND data. Programming never turns a 0 bit into a 1.
- R3: After a program or erase setup, or after 70h, the read port returns the status byte in bits 7:0 with zeros above it. This holds whatever the read address is, and it lasts until FFh is written in idle.
- R4: Status bit 7 reads 0 for exactly PGM_CYCLES cycles after a program launch and for exactly ERS_CYCLES cycles after an erase launch. Host writes made while busy have no effect.
- R5: The program verify sets status bit 4 only when a bit that the data asks to clear stays 1. The fault mask marks the cells that fail in this way. Writing a 1 over a stored 0 is not an error.
- R6: Writing 30h and then D0h sets every word of every eligible block to all ones when the engine finishes.
- R7: In erase setup, a second write other than D0h sets status bits 4 and 5, erases nothing and returns to idle at once.
- R8: If the voltage-good input is low, an erase confirm sets bits 3 and 5 and a program data write sets bits 3 and 4. In both cases the array is left unchanged and the engine never goes busy.
- R9: When write-protect is low, erase clears only the blocks whose lock input is 0. A program to a locked block sets bits 1 and 4 and leaves the word unchanged. When write-protect is high, locks are ignored.
- R10: Chip erase cannot be suspended. The suspend opcode B0h written during an erase changes neither the busy time nor the result.
- R11: Opcode 50h in idle clears status bits 1, 3, 4 and 5. Error bits otherwise stay set until they are cleared this way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | AW | Word address of the host write |
| wr_data | input | DW | Host write data; opcode in bits 7:0 |
| vpp_ok | input | 1 | Programming voltage is valid |
| wp_n | input | 1 | Write-protect, active low; when low, lock inputs are honoured |
| lock_bits | input | 2**(AW-WPB_LOG) | Lock flag per block |
| fault_mask | input | DW | Bit positions whose cells fail to program |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Array word, or the zero-extended status byte |
| status | output | 8 | Status register: bit 7 ready, bit 5 erase error, bit 4 program error, bit 3 voltage error, bit 1 lock error |

## Verification
The embedded properties check several rules on every clock:
- An erase, once running, is never cut short.
- An erase confirm with the voltage low leaves the engine idle and raises the voltage and erase flags.
- A bad confirm raises both error flags.
- Clear Status leaves the four error flags low.
- The read path stays in status mode whenever the controller is away from idle.
- No array bit rises from 0 to 1 outside an erase commit.

Several behaviours depend on a whole sequence and are left to the bench scenarios, which run against a behavioural model compared on every cycle:
- the exact busy length;
- the AND-only programming result;
- verify failures caused by the fault mask;
- writes ignored while busy, including the suspend opcode;
- lock-aware erase under write-protect.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PGM_SETUP,
        ST_ERS_SETUP,
        ST_PGM_BUSY,
        ST_ERS_BUSY
    } fc_state_e;

    localparam logic [7:0] OP_PGM     = 8'h40;
    localparam logic [7:0] OP_PGM_ALT = 8'h10;
    localparam logic [7:0] OP_ERS     = 8'h30;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_CLR     = 8'h50;
    localparam logic [7:0] OP_RDSR    = 8'h70;
    localparam logic [7:0] OP_RDARR   = 8'hFF;

    localparam int SR_LOCK = 1;
    localparam int SR_VPP  = 3;
    localparam int SR_PGM  = 4;
    localparam int SR_ERS  = 5;
    localparam int SR_RDY  = 7;

    localparam logic [7:0] SR_CLR_MASK = 8'h3A;

endpackage

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
    parameter int DW      = 16,
    parameter int AW      = 4,
    parameter int WPB_LOG = 2,
    localparam int NWORDS = 2 ** AW,
    localparam int NBLK   = 2 ** (AW - WPB_LOG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pgm_commit,
    input  logic            ers_commit,
    input  logic [AW-1:0]   op_addr,
    input  logic [DW-1:0]   op_data,
    input  logic [DW-1:0]   fault_mask,
    input  logic [NBLK-1:0] ers_mask,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_word,
    output logic            vfy_fail
);

    logic [DW-1:0] mem [NWORDS];

    // A cell that stays 1 while the data asks for 0 is a verify failure.
    assign vfy_fail = |(mem[op_addr] & fault_mask & ~op_data);
    assign rd_word  = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= '1;
        end else if (ers_commit) begin
            for (int i = 0; i < NWORDS; i++)
                if (ers_mask[i >> WPB_LOG]) mem[i] <= '1;
        end else if (pgm_commit) begin
            mem[op_addr] <= mem[op_addr] & (op_data | fault_mask);
        end
    end

    generate
        for (genvar g = 0; g < NWORDS; g++) begin : g_chk
            AST_NO_ONES_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(ers_commit) |-> ((mem[g] & ~$past(mem[g])) == '0)); // R2
        end
    endgenerate

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int DW         = 16,
    parameter int AW         = 4,
    parameter int WPB_LOG    = 2,
    parameter int PGM_CYCLES = 6,
    parameter int ERS_CYCLES = 12,
    localparam int NBLK      = 2 ** (AW - WPB_LOG),
    localparam int MAXC      = (PGM_CYCLES > ERS_CYCLES) ? PGM_CYCLES : ERS_CYCLES,
    localparam int CW        = $clog2(MAXC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            vpp_ok,
    input  logic            wp_n,
    input  logic [NBLK-1:0] lock_bits,
    input  logic            vfy_fail,
    output logic            pgm_commit,
    output logic            ers_commit,
    output logic [AW-1:0]   op_addr,
    output logic [DW-1:0]   op_data,
    output logic [NBLK-1:0] ers_mask,
    output logic            rd_status,
    output logic [7:0]      status
);

    fc_state_e st, nxt;
    logic [CW-1:0] cnt;
    logic [7:0]    err;
    logic [7:0]    err_set;
    logic          launch_p, launch_e, rs_set, rs_clr, clr;
    logic [7:0]    cmd;
    logic          busy, last;

    assign cmd    = wr_data[7:0];
    assign busy   = (st == ST_PGM_BUSY) || (st == ST_ERS_BUSY);
    assign last   = (cnt == CW'(1));
    assign status = err | {~busy, 7'b0};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Next state and per-cycle controls
    always_comb begin
        nxt        = st;
        err_set    = '0;
        launch_p   = 1'b0;
        launch_e   = 1'b0;
        rs_set     = 1'b0;
        rs_clr     = 1'b0;
        clr        = 1'b0;
        pgm_commit = 1'b0;
        ers_commit = 1'b0;
        unique case (st)
            ST_IDLE: if (wr_en) begin
                case (cmd)
                    OP_PGM, OP_PGM_ALT: begin nxt = ST_PGM_SETUP; rs_set = 1'b1; end
                    OP_ERS:             begin nxt = ST_ERS_SETUP; rs_set = 1'b1; end
                    OP_CLR:             clr    = 1'b1;
                    OP_RDSR:            rs_set = 1'b1;
                    OP_RDARR:           rs_clr = 1'b1;
                    default:            ;
                endcase
            end
            ST_PGM_SETUP: if (wr_en) begin
                rs_set = 1'b1;
                if (!vpp_ok) begin
                    err_set[SR_VPP] = 1'b1; err_set[SR_PGM] = 1'b1; nxt = ST_IDLE;
                end else if (lock_bits[wr_addr[AW-1:WPB_LOG]] && !wp_n) begin
                    err_set[SR_LOCK] = 1'b1; err_set[SR_PGM] = 1'b1; nxt = ST_IDLE;
                end else begin
                    launch_p = 1'b1; nxt = ST_PGM_BUSY;
                end
            end
            ST_ERS_SETUP: if (wr_en) begin
                rs_set = 1'b1;
                if (cmd != OP_CONFIRM) begin
                    err_set[SR_PGM] = 1'b1; err_set[SR_ERS] = 1'b1; nxt = ST_IDLE;
                end else if (!vpp_ok) begin
                    err_set[SR_VPP] = 1'b1; err_set[SR_ERS] = 1'b1; nxt = ST_IDLE;
                end else begin
                    launch_e = 1'b1; nxt = ST_ERS_BUSY;
                end
            end
            ST_PGM_BUSY: if (last) begin
                pgm_commit = 1'b1;
                err_set[SR_PGM] = vfy_fail;
                nxt = ST_IDLE;
            end
            ST_ERS_BUSY: if (last) begin
                ers_commit = 1'b1;
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            err       <= '0;
            rd_status <= 1'b0;
            op_addr   <= '0;
            op_data   <= '0;
            ers_mask  <= '0;
        end else begin
            if (launch_p)  cnt <= CW'(PGM_CYCLES);
            else if (launch_e) cnt <= CW'(ERS_CYCLES);
            else if (busy) cnt <= cnt - CW'(1);
            err <= (err | err_set) & ~(clr ? SR_CLR_MASK : 8'h00);
            if (rs_set)      rd_status <= 1'b1;
            else if (rs_clr) rd_status <= 1'b0;
            if (launch_p) begin
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
            if (launch_e) ers_mask <= wp_n ? '1 : ~lock_bits;
        end
    end

    AST_ERASE_NO_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERS_BUSY && !last) |=> (st == ST_ERS_BUSY)); // R10
    AST_VPP_ERASE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERS_SETUP && wr_en && cmd == OP_CONFIRM && !vpp_ok)
        |=> (st == ST_IDLE && status[SR_ERS] && status[SR_VPP])); // R8
    AST_BAD_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERS_SETUP && wr_en && cmd != OP_CONFIRM)
        |=> (status[SR_ERS] && status[SR_PGM] && status[SR_RDY])); // R7
    AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && wr_en && cmd == OP_CLR) |=> ((status & SR_CLR_MASK) == 8'h00)); // R11
    AST_STATUS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> rd_status); // R3

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if #(
    parameter int DW         = 16,
    parameter int AW         = 4,
    parameter int WPB_LOG    = 2,
    parameter int PGM_CYCLES = 6,
    parameter int ERS_CYCLES = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [DW-1:0]                 wr_data,
    input  logic                          vpp_ok,
    input  logic                          wp_n,
    input  logic [2**(AW-WPB_LOG)-1:0]    lock_bits,
    input  logic [DW-1:0]                 fault_mask,
    input  logic [AW-1:0]                 rd_addr,
    output logic [DW-1:0]                 rd_data,
    output logic [7:0]                    status
);

    localparam int NBLK = 2 ** (AW - WPB_LOG);

    logic            pgm_commit, ers_commit, vfy_fail, rd_status;
    logic [AW-1:0]   op_addr;
    logic [DW-1:0]   op_data, rd_word;
    logic [NBLK-1:0] ers_mask;

    flash_cmd_ctrl #(
        .DW(DW), .AW(AW), .WPB_LOG(WPB_LOG),
        .PGM_CYCLES(PGM_CYCLES), .ERS_CYCLES(ERS_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .vpp_ok(vpp_ok), .wp_n(wp_n), .lock_bits(lock_bits), .vfy_fail(vfy_fail),
        .pgm_commit(pgm_commit), .ers_commit(ers_commit), .op_addr(op_addr),
        .op_data(op_data), .ers_mask(ers_mask), .rd_status(rd_status), .status(status)
    );

    flash_cell_array #(.DW(DW), .AW(AW), .WPB_LOG(WPB_LOG)) u_array (
        .clk(clk), .rst_n(rst_n), .pgm_commit(pgm_commit), .ers_commit(ers_commit),
        .op_addr(op_addr), .op_data(op_data), .fault_mask(fault_mask),
        .ers_mask(ers_mask), .rd_addr(rd_addr), .rd_word(rd_word), .vfy_fail(vfy_fail)
    );

    assign rd_data = rd_status ? {{(DW-8){1'b0}}, status} : rd_word;

endmodule

// File: tb/flash_cmd_if_bench.sv
module flash_cmd_if_bench;

    localparam int DW = 16, AW = 4, WPB_LOG = 2, PGM = 6, ERS = 12;
    localparam int NW = 16;

    logic          clk = 0, rst_n = 0;
    logic          wr_en = 0, vpp_ok = 1, wp_n = 1;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0, fault_mask = '0;
    logic [3:0]    lock_bits = '0;
    logic [DW-1:0] rd_data;
    logic [7:0]    status;

    int nvec = 0, nfail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flash_cmd_if #(.DW(DW), .AW(AW), .WPB_LOG(WPB_LOG), .PGM_CYCLES(PGM), .ERS_CYCLES(ERS))
    u_flash_cmd_if (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .vpp_ok(vpp_ok), .wp_n(wp_n), .lock_bits(lock_bits), .fault_mask(fault_mask),
        .rd_addr(rd_addr), .rd_data(rd_data), .status(status)
    );

    // Behavioural reference: phase 0 idle, 1 wait data, 2 wait confirm, 3 programming, 4 erasing
    int            m_ph, m_left;
    bit            m_rs;
    logic [7:0]    m_err;
    logic [DW-1:0] m_mem [NW];
    int            m_a;
    logic [DW-1:0] m_d;
    logic [3:0]    m_keep;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_rs = 0; m_err = 0;
            foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
        end else begin
            case (m_ph)
                0: if (wr_en) begin
                    if (wr_data[7:0] == 8'h40 || wr_data[7:0] == 8'h10) begin m_ph = 1; m_rs = 1; end
                    else if (wr_data[7:0] == 8'h30) begin m_ph = 2; m_rs = 1; end
                    else if (wr_data[7:0] == 8'h50) m_err = m_err & 8'hC5;
                    else if (wr_data[7:0] == 8'h70) m_rs = 1;
                    else if (wr_data[7:0] == 8'hFF) m_rs = 0;
                end
                1: if (wr_en) begin
                    m_rs = 1; m_ph = 0;
                    if (!vpp_ok) m_err = m_err | 8'h18;
                    else if (lock_bits[wr_addr / 4] && !wp_n) m_err = m_err | 8'h12;
                    else begin m_a = wr_addr; m_d = wr_data; m_left = PGM; m_ph = 3; end
                end
                2: if (wr_en) begin
                    m_rs = 1; m_ph = 0;
                    if (wr_data[7:0] != 8'hD0) m_err = m_err | 8'h30;
                    else if (!vpp_ok) m_err = m_err | 8'h28;
                    else begin m_keep = wp_n ? 4'h0 : lock_bits; m_left = ERS; m_ph = 4; end
                end
                3: if (m_left == 1) begin
                    logic [DW-1:0] nw;
                    nw = m_mem[m_a] & (m_d | fault_mask);
                    if ((nw & ~m_d) != 0) m_err = m_err | 8'h10;
                    m_mem[m_a] = nw; m_ph = 0;
                end else m_left--;
                4: if (m_left == 1) begin
                    for (int i = 0; i < NW; i++) if (!m_keep[i / 4]) m_mem[i] = 16'hFFFF;
                    m_ph = 0;
                end else m_left--;
                default: m_ph = 0;
            endcase
        end
    end

    function automatic logic [7:0] m_status();
        return m_err | ((m_ph >= 3) ? 8'h00 : 8'h80);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R3 read path, R4 ready timing)
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R4 cycle status", status, m_status());
            chk("R3 cycle read", rd_data, m_rs ? {8'h00, m_status()} : m_mem[rd_addr]);
        end
    end

    task automatic wr(int a, logic [15:0] d);
        wr_addr = AW'(a); wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(string tag, int a, logic [15:0] exp);
        rd_addr = AW'(a);
        #1;
        chk(tag, rd_data, exp);
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        idle(4);
        @(negedge clk) rst_n = 1;
        // R1 reset state
        chk("R1 reset status", status, 8'h80);
        rd_chk("R1 reset array", 3, 16'hFFFF);

        // R2 and R4 program with 40h
        wr(0, 16'h0040); wr(5, 16'h1234);
        chk("R4 busy after launch", status, 8'h00);
        idle(PGM - 1);
        chk("R4 still busy at last cycle", status, 8'h00);
        idle(1);
        chk("R4 ready after program", status, 8'h80);
        rd_chk("R3 status read after program", 9, 16'h0080);
        wr(0, 16'h00FF);
        rd_chk("R2 programmed word", 5, 16'h1234);

        // R2 alternate opcode, AND-only; R4 writes ignored while busy
        wr(0, 16'h0010); wr(5, 16'hFF00);
        wr(0, 16'h00FF); wr(0, 16'h0050);
        idle(PGM);
        chk("R4 ready", status, 8'h80);
        rd_chk("R4 FFh during busy ignored", 5, 16'h0080);
        wr(0, 16'h00FF);
        rd_chk("R2 only clears bits", 5, 16'h1200);

        // R5 verify failure, then R11 clear
        fault_mask = 16'h0001;
        wr(0, 16'h0040); wr(6, 16'hFFFE); idle(PGM);
        chk("R5 verify failure flag", status, 8'h90);
        wr(0, 16'h0050);
        chk("R11 clear status", status, 8'h80);
        wr(0, 16'h0040); wr(5, 16'hFFFF); idle(PGM);
        chk("R5 one over zero no error", status, 8'h80);
        wr(0, 16'h00FF);
        rd_chk("R5 failed cell stays one", 6, 16'hFFFF);
        rd_chk("R5 word unchanged", 5, 16'h1200);
        fault_mask = 16'h0000;

        // R7 bad confirm, R11 sticky until cleared
        wr(0, 16'h0030); wr(0, 16'h0055);
        chk("R7 bad confirm flags", status, 8'hB0);
        wr(0, 16'h0070);
        chk("R11 errors sticky", status, 8'hB0);
        wr(0, 16'h0050);

        // R8 voltage low
        vpp_ok = 0;
        wr(0, 16'h0030); wr(0, 16'h00D0);
        chk("R8 erase with low voltage", status, 8'hA8);
        wr(0, 16'h0050);
        wr(0, 16'h0040); wr(5, 16'h0000);
        chk("R8 program with low voltage", status, 8'h98);
        wr(0, 16'h0050); wr(0, 16'h00FF);
        rd_chk("R8 array untouched", 5, 16'h1200);
        vpp_ok = 1;

        // R9 locks under write-protect
        lock_bits = 4'b0010; wp_n = 0;
        wr(0, 16'h0040); wr(4, 16'h0000);
        chk("R9 locked program flags", status, 8'h92);
        wr(0, 16'h0050);
        wp_n = 1;
        wr(0, 16'h0040); wr(4, 16'h00FF); idle(PGM);
        wr(0, 16'h0040); wr(0, 16'h0000); idle(PGM);
        wr(0, 16'h0040); wr(12, 16'hABCD); idle(PGM);
        wr(0, 16'h00FF);
        rd_chk("R9 lock ignored with protect high", 4, 16'h00FF);
        wp_n = 0;
        wr(0, 16'h0030); wr(0, 16'h00D0); idle(ERS);
        chk("R6 erase done", status, 8'h80);
        wr(0, 16'h00FF);
        rd_chk("R9 unlocked block erased", 0, 16'hFFFF);
        rd_chk("R9 unlocked block erased", 12, 16'hFFFF);
        rd_chk("R9 locked block kept", 5, 16'h1200);
        rd_chk("R9 locked block kept", 4, 16'h00FF);

        // R10 suspend ignored, R6 full erase
        wp_n = 1;
        wr(0, 16'h0030); wr(0, 16'h00D0);
        idle(3); wr(0, 16'h00B0);
        idle(ERS - 5);
        chk("R10 still busy after suspend", status, 8'h00);
        idle(1);
        chk("R10 erase ends on time", status, 8'h80);
        wr(0, 16'h00FF);
        rd_chk("R6 chip erased", 5, 16'hFFFF);
        rd_chk("R6 chip erased", 4, 16'hFFFF);

        // R3 70h enters status mode, FFh leaves it
        wr(0, 16'h0070);
        rd_chk("R3 read status command", 2, 16'h0080);
        wr(0, 16'h00FF);
        rd_chk("R3 read array command", 2, 16'hFFFF);

        idle(2);
        finish_run();
    end

endmodule